// File: doc/BRIEF.md
# Tone-shift keyed audio demodulator with symbol clock recovery

The block turns a stream of signed 8-bit audio samples, carrying a two-tone frequency-shift keyed signal at 1200 bit/s, into decoded data bits. One sample arrives on each cycle in which the sample-enable input is high. The nominal rate is 9600 samples per second, which gives eight samples per bit. Each sample is multiplied with the sample taken half a bit (four enables) earlier. The product is smoothed by a first-order low-pass recursive filter whose feedback uses only shifts and adds. The sign of the filter output is a raw bit stream.

A small phase counter recovers the symbol clock from transitions in that raw stream. Once per bit period it picks the latest raw bit as a symbol. The symbol is then decoded from change-of-level coding: an unchanged level means 1 and a change means 0. The block sits between a sampling front end and a framing layer. Each decoded bit comes out with a one-cycle valid strobe.

Top module: `tone_demod`

## Requirements
- R1: After an asynchronous reset (rst_ni low), bit_o and bit_vld_o are 0. The half-bit delay line, the filter state, the phase counter, the last raw bit and the previous symbol are all 0.
- R2: State and outputs change only on clock edges where smp_en_i is 1. While smp_en_i is 0, smp_i has no effect, bit_o holds and bit_vld_o stays 0.
- R3: The discriminator value for a sample is (current sample × sample from four enables earlier) arithmetically shifted right by 2, sign-extended to 16 bits. The delay line starts from zeros, so the first four products are 0.
- R4: The filter computes y = x_prev + x + (y_prev>>>1) + (y_prev>>>3) + (y_prev>>>5) in 16-bit two's complement with wrap-around. x_prev and y_prev are the values from the previous enabled sample.
- R5: A raw bit is 1 when the new filter output is strictly greater than zero, and 0 otherwise.
- R6: On each enable, the phase counter (range 0..63) is first nudged when the new raw bit differs from the previous raw bit: +1 if the counter is below 32, −1 otherwise. The counter then advances by 8.
- R7: When the advanced counter reaches 64 or more, it is reduced by 64 and the new raw bit becomes a symbol. bit_vld_o is then 1 in the cycle after that enable edge.
- R8: bit_o is 1 when the symbol equals the previous symbol and 0 when it differs. The previous symbol starts at 0.
- R9: bit_vld_o is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample strobe, one cycle per audio sample |
| smp_i | input | 8 | Signed audio sample |
| bit_o | output | 1 | Decoded data bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a new decoded bit |

## Verification
A phase nudge and a symbol pick can fall on the same enable. In that case the nudged value is the one that crosses the wrap. For example, 63 with a transition becomes 62 + 8 = 70 and wraps to 6, and a symbol is taken. The bench provokes this by sending tones whose bit length alternates between seven and nine samples. This keeps transitions drifting across the wrap point. A reference model in the bench, written from the requirements, predicts whether each enable yields a symbol and what its decoded value is. A scoreboard compares every strobe against that prediction, in order.

// File: rtl/tone_demod_pkg.sv
package tone_demod_pkg;
  typedef struct packed {
    logic vld;
    logic sym;
  } sym_evt_t;
endpackage

// File: rtl/tone_demod_discrim.sv
// Delay-and-multiply discriminator (R3)
module tone_demod_discrim #(
  parameter int SMP_W = 8,
  parameter int DLY   = 4,
  parameter int SHR   = 2,
  parameter int ACC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic signed [ACC_W-1:0] prod_o
);
  localparam int MUL_W = 2 * SMP_W;

  logic signed [SMP_W-1:0] dly_q [DLY];
  logic signed [MUL_W-1:0] mul;
  logic signed [ACC_W-1:0] mul_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q[0] <= '0;
    else if (en_i) dly_q[0] <= smp_i;
  end

  for (genvar k = 1; k < DLY; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[k] <= '0;
      else if (en_i) dly_q[k] <= dly_q[k-1];
    end
  end

  assign mul     = smp_i * dly_q[DLY-1];
  assign mul_ext = ACC_W'(mul);
  assign prod_o  = mul_ext >>> SHR;
endmodule

// File: rtl/tone_demod_lpf.sv
// First-order shift-add low-pass (R4)
module tone_demod_lpf #(
  parameter int ACC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] y_nxt_o
);
  logic signed [ACC_W-1:0] x_prev_q, y_q;

  // feedback ~0.656 = 1/2 + 1/8 + 1/32
  assign y_nxt_o = x_prev_q + x_i + (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_prev_q <= '0;
      y_q      <= '0;
    end else if (en_i) begin
      x_prev_q <= x_i;
      y_q      <= y_nxt_o;
    end
  end
endmodule

// File: rtl/tone_demod_clkrec.sv
// Nudged phase accumulator symbol picker (R6, R7)
module tone_demod_clkrec
  import tone_demod_pkg::*;
#(
  parameter int PH_STEP = 8,
  parameter int PH_WRAP = 64,
  parameter int PH_W    = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            slice_i,
  output sym_evt_t        evt_o,
  output logic [PH_W-1:0] ph_o
);
  localparam logic [PH_W-1:0] HALF = PH_W'(PH_WRAP / 2);
  localparam logic [PH_W-1:0] WRAP = PH_W'(PH_WRAP);
  localparam logic [PH_W-1:0] STEP = PH_W'(PH_STEP);

  logic [PH_W-1:0] ph_q, ph_nudge, ph_sum, ph_d;
  logic            slice_q, edge_seen, take;

  assign edge_seen = slice_i ^ slice_q;

  always_comb begin
    ph_nudge = ph_q;
    if (edge_seen) ph_nudge = (ph_q < HALF) ? ph_q + PH_W'(1) : ph_q - PH_W'(1);
    ph_sum = ph_nudge + STEP;
    take   = (ph_sum >= WRAP);
    ph_d   = take ? ph_sum - WRAP : ph_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      slice_q <= 1'b0;
    end else if (en_i) begin
      ph_q    <= ph_d;
      slice_q <= slice_i;
    end
  end

  assign evt_o.vld = en_i & take;
  assign evt_o.sym = slice_i;
  assign ph_o      = ph_q;
endmodule

// File: rtl/tone_demod_nrzi.sv
// Change-of-level decoder with output strobe (R8, R9)
module tone_demod_nrzi
  import tone_demod_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sym_evt_t evt_i,
  output logic     bit_o,
  output logic     vld_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      bit_o  <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= evt_i.vld;
      if (evt_i.vld) begin
        bit_o  <= (evt_i.sym == prev_q);
        prev_q <= evt_i.sym;
      end
    end
  end
endmodule

// File: rtl/tone_demod.sv
module tone_demod
  import tone_demod_pkg::*;
#(
  parameter int SMP_W   = 8,
  parameter int DLY     = 4,
  parameter int SHR     = 2,
  parameter int ACC_W   = 16,
  parameter int PH_STEP = 8,
  parameter int PH_WRAP = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             bit_o,
  output logic             bit_vld_o
);
  localparam int PH_W = $clog2(PH_WRAP + PH_STEP + 2);

  logic signed [ACC_W-1:0] prod_w, y_nxt_w;
  logic                    slice_w;
  sym_evt_t                evt_w;
  logic [PH_W-1:0]         ph_w;

  tone_demod_discrim #(.SMP_W(SMP_W), .DLY(DLY), .SHR(SHR), .ACC_W(ACC_W)) u_disc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_en_i),
    .smp_i($signed(smp_i)), .prod_o(prod_w)
  );

  tone_demod_lpf #(.ACC_W(ACC_W)) u_lpf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_en_i),
    .x_i(prod_w), .y_nxt_o(y_nxt_w)
  );

  // R5: strictly positive slices to 1
  assign slice_w = !y_nxt_w[ACC_W-1] && (y_nxt_w != '0);

  tone_demod_clkrec #(.PH_STEP(PH_STEP), .PH_WRAP(PH_WRAP), .PH_W(PH_W)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_en_i),
    .slice_i(slice_w), .evt_o(evt_w), .ph_o(ph_w)
  );

  tone_demod_nrzi u_nrzi (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_w),
    .bit_o(bit_o), .vld_o(bit_vld_o)
  );
endmodule

// File: rtl/tone_demod_chk.sv
module tone_demod_chk #(
  parameter int PH_STEP = 8,
  parameter int PH_WRAP = 64,
  parameter int PH_W    = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            smp_en_i,
  input logic            bit_o,
  input logic            bit_vld_o,
  input logic [PH_W-1:0] ph_i
);
  // R9
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);

  // R7
  vld_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(smp_en_i));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> ($stable(bit_o) && $stable(ph_i)));

  // R6
  ph_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ph_i) < PH_WRAP);

  // R6
  ph_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i |=> ((int'(ph_i) - int'($past(ph_i)) + PH_WRAP) % PH_WRAP)
                 inside {[PH_STEP-1:PH_STEP+1]});
endmodule

bind tone_demod tone_demod_chk #(.PH_STEP(PH_STEP), .PH_WRAP(PH_WRAP), .PH_W(PH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_en_i(smp_en_i),
  .bit_o(bit_o), .bit_vld_o(bit_vld_o), .ph_i(ph_w)
);

// File: tb/tb_tone_demod.sv
module tb_tone_demod;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_en_i = 1'b0;
  logic [7:0] smp_i = '0;
  logic       bit_o, bit_vld_o;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_dly[4];
  int m_xp, m_y, m_ph, m_sl, m_sym;

  always #4 clk_i = ~clk_i;

  tone_demod dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_en_i(smp_en_i), .smp_i(smp_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );

  function automatic int rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr);
  endfunction

  // R3 R4 R5 R6 R7 R8 reference
  task automatic model_step(int s);
    int x, yn, ph;
    bit sl;
    x = (s * m_dly[3]) >>> 2;
    for (int k = 3; k > 0; k--) m_dly[k] = m_dly[k-1];
    m_dly[0] = s;
    yn = m_xp + x + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5);
    yn = int'(shortint'(yn));
    m_xp = x;
    m_y = yn;
    sl = (yn > 0);
    ph = m_ph;
    if (int'(sl) != m_sl) ph = (ph < 32) ? ph + 1 : ph - 1;
    ph = ph + 8;
    m_sl = int'(sl);
    if (ph >= 64) begin
      ph = ph - 64;
      exp_q.push_back(int'(sl) == m_sym);
      m_sym = int'(sl);
    end
    m_ph = ph;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && bit_vld_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected strobe: actual bit=%0d expected none", bit_o);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (bit_o !== e) begin
          errors++;
          $display("FAIL R8 decoded bit: actual %0d expected %0d", bit_o, e);
        end
      end
    end
  end

  // drive one sample at a negedge, then 'gap' idle cycles with junk on smp_i (R2)
  task automatic drive(int s, int gap);
    logic b;
    smp_i = 8'(s);
    smp_en_i = 1'b1;
    model_step(s);
    @(negedge clk_i);
    if (gap > 0) begin
      smp_en_i = 1'b0;
      b = bit_o;
      for (int i = 0; i < gap; i++) begin
        smp_i = 8'(rnd());
        @(negedge clk_i);
        checks++;
        if (bit_vld_o !== 1'b0 || bit_o !== b) begin
          errors++;
          $display("FAIL R2 idle: actual vld=%0d bit=%0d expected vld=0 bit=%0d",
                   bit_vld_o, bit_o, b);
        end
      end
    end
  endtask

  // mode 0: 8 samples/bit, 1: alternating 7/9 (drift), 2: hard-clipped
  task automatic send_bits(int nbits, int mode, real amp);
    real ph, f, v;
    int spb, s;
    ph = 0.0;
    f = 1200.0;
    for (int b = 0; b < nbits; b++) begin
      if (rnd() % 2 == 0) f = (f == 1200.0) ? 2200.0 : 1200.0;
      spb = (mode == 1) ? ((b % 2 == 1) ? 9 : 7) : 8;
      for (int k = 0; k < spb; k++) begin
        v = amp * $sin(ph);
        s = $rtoi(v);
        if (mode == 2) s = (v >= 0.0) ? 127 : -128;
        ph = ph + 2.0 * 3.14159265358979 * f / 9600.0;
        drive(s, rnd() % 4);
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) m_dly[k] = 0;
    m_xp = 0; m_y = 0; m_ph = 0; m_sl = 0; m_sym = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    checks++;
    if (bit_o !== 1'b0 || bit_vld_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual bit=%0d vld=%0d expected 0 0", bit_o, bit_vld_o);
    end
    // R1 R3 R8: silence, symbols all 0, decoded as 1
    for (int i = 0; i < 40; i++) drive(0, 1);
    // R3 R4 R5 R6 R7 R8: clean tones, random gaps including back-to-back enables
    send_bits(64, 0, 100.0);
    // R6 R7: drifting bit length forces nudges and nudge-with-wrap
    send_bits(64, 1, 120.0);
    // R4: full-scale samples
    send_bits(32, 2, 127.0);
    // R5 R6: noise
    for (int i = 0; i < 400; i++) drive(rnd() % 256 - 128, rnd() % 3);
    smp_en_i = 1'b0;
    repeat (10) @(negedge clk_i);
    // R7 R9: every predicted symbol was strobed exactly once
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 missing strobes: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule